// File: doc/BRIEF.md
# Clock-Multiplier Bring-Up Sequencer

This block is the control front end that brings an on-chip clock-multiplier loop into service in a safe order. Software stages changes through a small register interface. These changes are the loop configuration and the enable/connect control. A staged change has no effect until an unlock pair of writes commits it. Each committed pair carries exactly one step. The loop therefore has to be configured, then enabled, then given a valid CPU divider, then found locked, and only then connected. Each of these steps needs its own commit.

Lock is taken from the loop's lock indicator when the reference clock lies in the range where that indicator can be trusted. A two-bit reference-range code tells the block whether the indicator is trusted. When the reference is very fast, lock is declared after a fixed number of system clocks. When the reference is very slow, lock is declared after a fixed number of reference-rate ticks. A status register reports enable, connect and lock as separate bits. A sticky lock interrupt flag is set when lock is reached.

Register map (3-bit address, 8-bit data): 0 = loop configuration (staged), 1 = control (staged; bit0 enable, bit1 connect), 2 = CPU divider (direct), 3 = unlock, 4 = status (read: bit0 enabled, bit1 connected, bit2 locked, bit3 lock flag; writing 1 to bit3 clears the flag). Addresses 5 to 7 read as zero.

Top module: `pllStartSeq`

## Requirements
- R1: After reset, loopEnable, loopConnect, loopCfg, cpuDiv and lockIrq are 0 and the status register reads 0.
- R2: A write to address 0 only stages a configuration. loopCfg takes the staged value on the edge of a write of 0xAA to address 3 followed, as the very next write, by 0x55 to address 3. A configuration commit is ignored while the loop is enabled.
- R3: If any write other than 0x55 to address 3 follows an armed 0xAA, the pending change is discarded and the unlock is cancelled. A 0x55 without a preceding 0xAA commits nothing.
- R4: A single commit performs one step. A committed control value with enable=1 and connect=1 while the loop is disabled only enables it, and loopConnect stays 0.
- R5: A divider write of 0 or of an odd value updates cpuDiv on its own write edge, with no unlock needed. A write of a nonzero even value is ignored.
- R6: A committed connect request is ignored unless the loop is enabled, locked, and has received an accepted divider write since it was enabled.
- R7: With refCode 00, the locked status equals lockIn AND enabled, delayed by one clock.
- R8: With refCode 01, lockIn is ignored. Locked rises FAST_CYCLES+1 clocks after the enable commit edge.
- R9: With refCode 1x, lockIn is ignored. Locked rises one clock after the edge that samples the SLOW_TICKS-th refTick pulse since enable.
- R10: lockIrq sets on the edge where locked rises and stays set through other writes. A status write with bit3=1 clears it. Set wins over clear.
- R11: A committed control value with enable=0 clears loopEnable and loopConnect on the commit edge. Locked falls one clock later.
- R12: Status reads return {4'b0, lockFlag, locked, connected, enabled}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 8 | Read data (combinational) |
| lockIn | input | 1 | Lock indicator from the loop |
| refTick | input | 1 | One-cycle pulse per reference period |
| refCode | input | 2 | Reference range: 00 trusted, 01 fast, 1x slow |
| loopEnable | output | 1 | Loop power/enable |
| loopConnect | output | 1 | Select loop output as clock source |
| loopCfg | output | 8 | Committed loop configuration |
| cpuDiv | output | 8 | CPU clock divider setting |
| lockIrq | output | 1 | Sticky lock interrupt flag |

## Verification
The hardest state to reach is a successful connect. It needs four preconditions to line up: an enable commit, a legal divider written afterwards, lock, and a separate commit carrying connect. Each precondition is first withheld on its own and the connect attempt is shown to fail, and only then is the full order completed. Unlock abort is swept over every interrupting address and over wrong unlock values. The divider acceptance rule is swept over all 256 values. Both timeout modes are run at small parameter values so that the lock edge can be checked to the exact cycle.

// File: rtl/pllSeqPkg.sv
package pllSeqPkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_DIV  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_FEED = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd4;

  localparam logic [DATA_W-1:0] UNLOCK_FIRST  = 8'hAA;
  localparam logic [DATA_W-1:0] UNLOCK_SECOND = 8'h55;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_CON_BIT = 1;
  localparam int STAT_IRQ_BIT = 3;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_CFG  = 2'd1,
    PEND_CTRL = 2'd2
  } pendKindE;

  typedef enum logic {
    UNLK_IDLE  = 1'b0,
    UNLK_ARMED = 1'b1
  } unlockStateE;

  typedef struct packed {
    logic stageCfg;
    logic stageCtrl;
    logic divWr;
    logic irqClr;
    logic commit;
    logic discard;
  } seqStrobeS;
endpackage

// File: rtl/pllSeqCtrl.sv
module pllSeqCtrl
  import pllSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output seqStrobeS         strobes
);
  unlockStateE unlockState;
  logic        isUnlockAddr;

  assign isUnlockAddr = (wrAddr == ADDR_FEED);

  // Decode one bus write into datapath strobes.
  always_comb begin
    strobes = '0;
    if (wrEn) begin
      if (isUnlockAddr) begin
        if (unlockState == UNLK_ARMED) begin
          if (wrData == UNLOCK_SECOND) strobes.commit  = 1'b1;
          else                         strobes.discard = 1'b1;
        end
      end else begin
        // Any non-unlock write between the two halves cancels the pending step.
        if (unlockState == UNLK_ARMED) strobes.discard = 1'b1;
        unique case (wrAddr)
          ADDR_CFG:  strobes.stageCfg  = 1'b1;
          ADDR_CTRL: strobes.stageCtrl = 1'b1;
          ADDR_DIV:  strobes.divWr     = 1'b1;
          ADDR_STAT: strobes.irqClr    = wrData[STAT_IRQ_BIT];
          default:   ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unlockState <= UNLK_IDLE;
    end else if (wrEn) begin
      if (isUnlockAddr && unlockState == UNLK_IDLE && wrData == UNLOCK_FIRST)
        unlockState <= UNLK_ARMED;
      else
        unlockState <= UNLK_IDLE;
    end
  end
endmodule

// File: rtl/pllLockTimer.sv
module pllLockTimer #(
  parameter int FAST_CYCLES = 36000,
  parameter int SLOW_TICKS  = 200
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  input  logic slowMode,
  input  logic refTick,
  output logic expired
);
  localparam int MAX_COUNT = (FAST_CYCLES > SLOW_TICKS) ? FAST_CYCLES : SLOW_TICKS;
  localparam int CNT_W     = $clog2(MAX_COUNT + 1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] limit;
  logic             advance;

  assign limit   = slowMode ? CNT_W'(SLOW_TICKS) : CNT_W'(FAST_CYCLES);
  assign expired = (count >= limit);
  assign advance = run && !expired && (slowMode ? refTick : 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN || !run) count <= '0;
    else if (advance)  count <= count + 1'b1;
  end
endmodule

// File: rtl/pllSeqDatapath.sv
module pllSeqDatapath
  import pllSeqPkg::*;
#(
  parameter int FAST_CYCLES = 36000,
  parameter int SLOW_TICKS  = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeS         strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              lockIn,
  input  logic              refTick,
  input  logic [1:0]        refCode,
  output logic [DATA_W-1:0] rdData,
  output logic              loopEnable,
  output logic              loopConnect,
  output logic [DATA_W-1:0] loopCfg,
  output logic [DATA_W-1:0] cpuDiv,
  output logic              lockIrq,
  output logic              lockedState
);
  pendKindE          pendKind;
  logic [DATA_W-1:0] pendData;
  logic              divSet;
  logic              divLegal;
  logic              trusted;
  logic              slowMode;
  logic              tmrExpired;
  logic              lockedNext;

  assign trusted  = (refCode == 2'b00);
  assign slowMode = refCode[1];
  assign divLegal = (wrData == '0) || wrData[0];

  pllLockTimer #(
    .FAST_CYCLES(FAST_CYCLES),
    .SLOW_TICKS (SLOW_TICKS)
  ) uTimer (
    .clk     (clk),
    .rstN    (rstN),
    .run     (loopEnable && !trusted),
    .slowMode(slowMode),
    .refTick (refTick),
    .expired (tmrExpired)
  );

  assign lockedNext = loopEnable && (trusted ? lockIn : tmrExpired);

  // Pending slot: only one staged step exists at a time.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendKind <= PEND_NONE;
      pendData <= '0;
    end else begin
      if (strobes.discard || strobes.commit) pendKind <= PEND_NONE;
      if (strobes.stageCfg) begin
        pendKind <= PEND_CFG;
        pendData <= wrData;
      end else if (strobes.stageCtrl) begin
        pendKind <= PEND_CTRL;
        pendData <= wrData;
      end
    end
  end

  // Committed state: configuration, enable, connect, divider.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      loopCfg     <= '0;
      loopEnable  <= 1'b0;
      loopConnect <= 1'b0;
      cpuDiv      <= '0;
      divSet      <= 1'b0;
    end else begin
      if (strobes.commit) begin
        unique case (pendKind)
          PEND_CFG: begin
            if (!loopEnable) loopCfg <= pendData;
          end
          PEND_CTRL: begin
            if (!pendData[CTRL_EN_BIT]) begin
              loopEnable  <= 1'b0;
              loopConnect <= 1'b0;
              divSet      <= 1'b0;
            end else if (!loopEnable) begin
              loopEnable <= 1'b1;
              divSet     <= 1'b0;
            end else if (pendData[CTRL_CON_BIT]) begin
              if (lockedState && divSet) loopConnect <= 1'b1;
            end else begin
              loopConnect <= 1'b0;
            end
          end
          default: ;
        endcase
      end
      if (strobes.divWr && divLegal) begin
        cpuDiv <= wrData;
        if (loopEnable) divSet <= 1'b1;
      end
    end
  end

  // Lock tracking and the sticky flag.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockedState <= 1'b0;
      lockIrq     <= 1'b0;
    end else begin
      lockedState <= lockedNext;
      if (lockedNext && !lockedState) lockIrq <= 1'b1;
      else if (strobes.irqClr)        lockIrq <= 1'b0;
    end
  end

  always_comb begin
    unique case (rdAddr)
      ADDR_CFG:  rdData = loopCfg;
      ADDR_CTRL: rdData = {6'b0, loopConnect, loopEnable};
      ADDR_DIV:  rdData = cpuDiv;
      ADDR_STAT: rdData = {4'b0, lockIrq, lockedState, loopConnect, loopEnable};
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/pllStartSeq.sv
module pllStartSeq
  import pllSeqPkg::*;
#(
  parameter int FAST_CYCLES = 36000,
  parameter int SLOW_TICKS  = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [2:0] rdAddr,
  output logic [7:0] rdData,
  input  logic       lockIn,
  input  logic       refTick,
  input  logic [1:0] refCode,
  output logic       loopEnable,
  output logic       loopConnect,
  output logic [7:0] loopCfg,
  output logic [7:0] cpuDiv,
  output logic       lockIrq
);
  seqStrobeS strobes;
  logic      lockedState;

  pllSeqCtrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .strobes(strobes)
  );

  pllSeqDatapath #(
    .FAST_CYCLES(FAST_CYCLES),
    .SLOW_TICKS (SLOW_TICKS)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrData     (wrData),
    .rdAddr     (rdAddr),
    .lockIn     (lockIn),
    .refTick    (refTick),
    .refCode    (refCode),
    .rdData     (rdData),
    .loopEnable (loopEnable),
    .loopConnect(loopConnect),
    .loopCfg    (loopCfg),
    .cpuDiv     (cpuDiv),
    .lockIrq    (lockIrq),
    .lockedState(lockedState)
  );
endmodule

// File: rtl/pllStartSeqChk.sv
module pllStartSeqChk (
  input logic       clk,
  input logic       rstN,
  input logic       loopEnable,
  input logic       loopConnect,
  input logic [7:0] loopCfg,
  input logic [7:0] cpuDiv,
  input logic       lockIrq,
  input logic       lockIn,
  input logic [1:0] refCode,
  input logic       lockedState
);
  // R2: configuration only changes while the loop was disabled
  a_r2_cfg_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(loopCfg) |-> !$past(loopEnable));

  // R4: enabling never connects in the same step
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loopEnable) |-> !loopConnect);

  // R5: divider only ever holds zero or an odd value
  a_r5_div_legal: assert property (@(posedge clk) disable iff (!rstN)
    (cpuDiv == 8'd0) || cpuDiv[0]);

  // R6: connect only rises when the loop was already enabled and locked
  a_r6_connect_needs_lock: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loopConnect) |-> ($past(lockedState) && $past(loopEnable)));

  // R7: trusted mode locked follows lockIn by one clock
  a_r7_trusted_follow: assert property (@(posedge clk) disable iff (!rstN)
    ($past(refCode) == 2'b00) |-> (lockedState == ($past(lockIn) && $past(loopEnable))));

  // R10: flag set whenever lock rises
  a_r10_flag_on_lock: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockedState) |-> lockIrq);

  // R11: connected implies enabled; disabling drops connect
  a_r11_connect_implies_enable: assert property (@(posedge clk) disable iff (!rstN)
    loopConnect |-> loopEnable);

  a_r11_fall_drops_connect: assert property (@(posedge clk) disable iff (!rstN)
    $fell(loopEnable) |-> !loopConnect);
endmodule

bind pllStartSeq pllStartSeqChk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .loopEnable (loopEnable),
  .loopConnect(loopConnect),
  .loopCfg    (loopCfg),
  .cpuDiv     (cpuDiv),
  .lockIrq    (lockIrq),
  .lockIn     (lockIn),
  .refCode    (refCode),
  .lockedState(lockedState)
);

// File: tb/sim_pllStartSeq.sv
`timescale 1ns/1ps
module sim_pllStartSeq;
  localparam int FAST = 20;
  localparam int SLOW = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       lockIn = 1'b0;
  logic       refTick = 1'b0;
  logic [1:0] refCode = 2'b00;
  logic       loopEnable, loopConnect, lockIrq;
  logic [7:0] loopCfg, cpuDiv;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pllStartSeq #(.FAST_CYCLES(FAST), .SLOW_TICKS(SLOW)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .lockIn(lockIn), .refTick(refTick),
    .refCode(refCode), .loopEnable(loopEnable), .loopConnect(loopConnect),
    .loopCfg(loopCfg), .cpuDiv(cpuDiv), .lockIrq(lockIrq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic unlock();
    wr(3'd3, 8'hAA);
    wr(3'd3, 8'h55);
  endtask

  task automatic readReg(input logic [2:0] a, output logic [7:0] d);
    rdAddr = a;
    #0.5;
    d = rdData;
  endtask

  task automatic tick();
    @(negedge clk); refTick = 1'b1;
    @(negedge clk); refTick = 1'b0;
  endtask

  task automatic finishRun();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      finishRun();
    end
  end

  initial begin
    logic [7:0] st;
    logic [7:0] expDiv;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 enable", loopEnable, 0);
    chk("R1 connect", loopConnect, 0);
    chk("R1 cfg", loopCfg, 0);
    chk("R1 div", cpuDiv, 0);
    chk("R1 irq", lockIrq, 0);
    readReg(3'd4, st); chk("R1 status", st, 0);

    // R3: lone second half commits nothing
    wr(3'd1, 8'h01); wr(3'd3, 8'h55);
    chk("R3 lone 55", loopEnable, 0);

    // R3: sweep every interrupting address between the unlock halves
    for (int a = 0; a < 8; a++) begin
      logic [7:0] intData;
      intData = (a == 3) ? 8'h00 : ((a == 2) ? 8'h01 : 8'h00);
      wr(3'd1, 8'h01);
      wr(3'd3, 8'hAA);
      wr(3'(a), intData);
      wr(3'd3, 8'h55);
      chk("R3 abort enable", loopEnable, 0);
      unlock();
      chk("R3 discarded", loopEnable, 0);
    end
    // R3: repeated first half also cancels
    wr(3'd1, 8'h01); wr(3'd3, 8'hAA); wr(3'd3, 8'hAA); wr(3'd3, 8'h55);
    chk("R3 double AA", loopEnable, 0);

    // R2 staged config
    wr(3'd0, 8'h5A);
    chk("R2 staged only", loopCfg, 0);
    unlock();
    chk("R2 committed", loopCfg, 8'h5A);

    // R4 one step per commit
    refCode = 2'b00; lockIn = 1'b0;
    wr(3'd1, 8'h03); unlock();
    chk("R4 enabled", loopEnable, 1);
    chk("R4 not connected", loopConnect, 0);

    // R2 config ignored while enabled
    wr(3'd0, 8'h33); unlock();
    chk("R2 ignored when enabled", loopCfg, 8'h5A);

    // R6 connect before lock
    wr(3'd1, 8'h03); unlock();
    chk("R6 no lock", loopConnect, 0);

    // R7 trusted lock follows lockIn one clock later
    @(negedge clk); lockIn = 1'b1;
    readReg(3'd4, st); chk("R7 before edge", st[2], 0);
    @(negedge clk);
    readReg(3'd4, st); chk("R7 locked", st[2], 1);
    chk("R10 irq on lock", lockIrq, 1);

    // R6 connect without divider since enable
    wr(3'd1, 8'h03); unlock();
    chk("R6 no divider", loopConnect, 0);

    // R5 divider sweep over all values
    expDiv = cpuDiv;
    for (int v = 0; v < 256; v++) begin
      wr(3'd2, 8'(v));
      if (v == 0 || (v % 2) == 1) expDiv = 8'(v);
      chk("R5 divider", cpuDiv, expDiv);
    end

    // R10 sticky, clear by bit3
    wr(3'd4, 8'h07);
    chk("R10 stays", lockIrq, 1);
    wr(3'd4, 8'h08);
    chk("R10 cleared", lockIrq, 0);

    // R6 full order connects
    wr(3'd1, 8'h03); unlock();
    chk("R6 connected", loopConnect, 1);
    readReg(3'd4, st); chk("R12 status", st, 8'h07);

    // R11 disable
    wr(3'd1, 8'h00); unlock();
    chk("R11 enable off", loopEnable, 0);
    chk("R11 connect off", loopConnect, 0);
    readReg(3'd4, st); chk("R11 locked lingers", st[2], 1);
    @(negedge clk);
    readReg(3'd4, st); chk("R11 locked gone", st[2], 0);

    // R8 fast timeout, lockIn ignored
    refCode = 2'b01; lockIn = 1'b1;
    wr(3'd4, 8'h08);
    wr(3'd1, 8'h01); unlock();
    repeat (FAST) @(negedge clk);
    readReg(3'd4, st); chk("R8 not yet", st[2], 0);
    @(negedge clk);
    readReg(3'd4, st); chk("R8 locked", st[2], 1);
    chk("R10 irq timeout", lockIrq, 1);

    // R9 slow timeout on reference ticks
    wr(3'd1, 8'h00); unlock();
    refCode = 2'b10; lockIn = 1'b1;
    wr(3'd4, 8'h08);
    wr(3'd1, 8'h01); unlock();
    for (int k = 0; k < SLOW - 1; k++) tick();
    repeat (30) @(negedge clk);
    readReg(3'd4, st); chk("R9 waits ticks", st[2], 0);
    tick();
    readReg(3'd4, st); chk("R9 not yet", st[2], 0);
    @(negedge clk);
    readReg(3'd4, st); chk("R9 locked", st[2], 1);
    readReg(3'd4, st); chk("R12 status bits", st, 8'h09 | 8'h04);

    finishRun();
  end
endmodule